// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This unit computes a short integer dot product between two packed 32-bit operands and adds the sum to a 32-bit running value. It is meant for low-precision inference loops. A sequencer streams operand words and the previous partial sum into the unit, and takes the new partial sum back one cycle later.

Two lane layouts share the same operand buses. In quad mode both operands hold four bytes. In pair mode the first operand holds two 16-bit halves and the second operand holds two bytes, taken from its lower or upper half. Each operand has its own signedness control. The final addition wraps silently.

Top module: `dot_accum_unit`

## Requirements
- R1: While `rstN` is low and after it rises with no valid input, `outValid` is 0 and `result` is 0.
- R2: `outValid` is high in exactly the cycle after a cycle in which `inValid` was high, and low otherwise.
- R3: With `modePair` = 0 (quad mode), `result` = `accIn` + sum over k = 0..3 of `opA[8k+7:8k]` × `opB[8k+7:8k]`. Lane 0 sits in bits 7:0.
- R4: With `modePair` = 1 (pair mode), `result` = `accIn` + `opA[15:0]` × `opB` byte p + `opA[31:16]` × `opB` byte p+1. Here p = 0 when `hiSel` = 0 and p = 2 when `hiSel` = 1, and byte n is `opB[8n+7:8n]`.
- R5: `aSigned` = 1 makes every `opA` element two's complement; 0 makes it unsigned. `bSigned` does the same for `opB`. Each control acts on its own operand only.
- R6: The final addition is taken modulo 2^32. There is no saturation and no flag.
- R7: In a cycle with `inValid` = 0, `result` keeps its previous value whatever the other inputs are.
- R8: In quad mode `hiSel` has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands are present this cycle |
| modePair | input | 1 | 0 = four 8×8 lanes, 1 = two 16×8 lanes |
| aSigned | input | 1 | Treat `opA` elements as signed |
| bSigned | input | 1 | Treat `opB` elements as signed |
| hiSel | input | 1 | Pair mode: take bytes 2,3 of `opB` instead of bytes 0,1 |
| opA | input | 32 | Packed operand A |
| opB | input | 32 | Packed operand B |
| accIn | input | 32 | Value added to the dot product |
| outValid | output | 1 | `result` holds a new value |
| result | output | 32 | Accumulated dot product |

## Verification
The hardest cases are sums in which every lane gives an extreme product of the same sign, so the wrap of R6 depends on the exact extension of each lane. An example is 0x80 × 0x80 under each signedness pairing, or a 16-bit half of 0x8000 against a byte of 0xFF. The stimulus sweeps a set of boundary byte values across all lanes, with every signedness pairing and both modes and half selects. It then adds accumulator values near the wrap point and a long pseudo-random stream. The expected value is computed in 64-bit arithmetic from the requirement formulas.

// File: rtl/dot_accum_pkg.sv
package dot_accum_pkg;

  // Strobes handed from control to datapath for one operation
  typedef struct packed {
    logic load;      // capture a new sum this cycle
    logic pairMode;  // two wide lanes instead of four narrow ones
    logic extA;      // sign-extend elements of operand A
    logic extB;      // sign-extend elements of operand B
    logic useHigh;   // pair mode: upper bytes of operand B
  } dpCtl_t;

endpackage

// File: rtl/dot_accum_ctrl.sv
module dot_accum_ctrl
  import dot_accum_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   modePair,
  input  logic   aSigned,
  input  logic   bSigned,
  input  logic   hiSel,
  output dpCtl_t ctl,
  output logic   outValid
);

  always_comb begin
    ctl.load     = inValid;
    ctl.pairMode = modePair;
    ctl.extA     = aSigned;
    ctl.extB     = bSigned;
    // the half select only means something for the wide-lane layout
    ctl.useHigh  = modePair & hiSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/dot_accum_dp.sv
module dot_accum_dp
  import dot_accum_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtl_t                   ctl,
  input  logic [LANE_W*LANES-1:0]  opA,
  input  logic [LANE_W*LANES-1:0]  opB,
  input  logic [ACC_W-1:0]         accIn,
  output logic [ACC_W-1:0]         result
);

  localparam int WIDE_W = 2 * LANE_W;
  localparam int PAIRS  = LANES / 2;
  localparam int EXT_W  = WIDE_W + 1;
  localparam int PROD_W = 2 * EXT_W;
  localparam int SUM_W  = ((ACC_W > PROD_W) ? ACC_W : PROD_W) + 1;

  logic signed [EXT_W-1:0]  elA   [LANES];
  logic signed [EXT_W-1:0]  elB   [LANES];
  logic signed [PROD_W-1:0] prod  [LANES];
  logic signed [SUM_W-1:0]  term  [LANES];
  logic signed [SUM_W-1:0]  total;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] byteA, byteB;
    logic signed [EXT_W-1:0] quadA, quadB;
    assign byteA = opA[i*LANE_W +: LANE_W];
    assign byteB = opB[i*LANE_W +: LANE_W];
    assign quadA = {{(EXT_W-LANE_W){ctl.extA & byteA[LANE_W-1]}}, byteA};
    assign quadB = {{(EXT_W-LANE_W){ctl.extB & byteB[LANE_W-1]}}, byteB};

    if (i < PAIRS) begin : g_wide
      logic [WIDE_W-1:0] halfA;
      logic [LANE_W-1:0] selB;
      assign halfA = opA[i*WIDE_W +: WIDE_W];
      assign selB  = ctl.useHigh ? opB[(i+PAIRS)*LANE_W +: LANE_W]
                                 : opB[i*LANE_W +: LANE_W];
      assign elA[i] = ctl.pairMode ? {ctl.extA & halfA[WIDE_W-1], halfA} : quadA;
      assign elB[i] = ctl.pairMode
                      ? {{(EXT_W-LANE_W){ctl.extB & selB[LANE_W-1]}}, selB}
                      : quadB;
    end else begin : g_narrow
      // lanes past the wide pairs fall silent in pair mode
      assign elA[i] = ctl.pairMode ? '0 : quadA;
      assign elB[i] = ctl.pairMode ? '0 : quadB;
    end

    assign prod[i] = elA[i] * elB[i];
    assign term[i] = {{(SUM_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
  end

  always_comb begin
    total = {{(SUM_W-ACC_W){1'b0}}, accIn};
    for (int k = 0; k < LANES; k++) total = total + term[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         result <= '0;
    else if (ctl.load) result <= total[ACC_W-1:0];
  end

endmodule

// File: rtl/dot_accum_unit.sv
module dot_accum_unit
  import dot_accum_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter int ACC_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic                    modePair,
  input  logic                    aSigned,
  input  logic                    bSigned,
  input  logic                    hiSel,
  input  logic [LANE_W*LANES-1:0] opA,
  input  logic [LANE_W*LANES-1:0] opB,
  input  logic [ACC_W-1:0]        accIn,
  output logic                    outValid,
  output logic [ACC_W-1:0]        result
);

  dpCtl_t ctl;

  dot_accum_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modePair(modePair),
    .aSigned(aSigned), .bSigned(bSigned), .hiSel(hiSel),
    .ctl(ctl), .outValid(outValid)
  );

  dot_accum_dp #(.LANE_W(LANE_W), .LANES(LANES), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opA(opA), .opB(opB),
    .accIn(accIn), .result(result)
  );

endmodule

// File: rtl/dot_accum_chk.sv
module dot_accum_chk #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter int ACC_W  = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    modePair,
  input logic                    aSigned,
  input logic                    bSigned,
  input logic [LANE_W*LANES-1:0] opA,
  input logic [LANE_W*LANES-1:0] opB,
  input logic [ACC_W-1:0]        accIn,
  input logic                    outValid,
  input logic [ACC_W-1:0]        result
);

  localparam int WORD_W = LANE_W * LANES;

  logic [2*LANE_W-1:0] lowProd;
  assign lowProd = (2*LANE_W)'(opA[LANE_W-1:0]) * (2*LANE_W)'(opB[LANE_W-1:0]);

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));

  // R6
  acc_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opA == '0) |=> result == $past(accIn));

  // R5
  lane0_unsigned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !modePair && !aSigned && !bSigned && accIn == '0 &&
     opA[WORD_W-1:LANE_W] == '0)
    |=> result == ACC_W'($past(lowProd)));

endmodule

bind dot_accum_unit dot_accum_chk #(.LANE_W(LANE_W), .LANES(LANES), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .modePair(modePair),
  .aSigned(aSigned), .bSigned(bSigned), .opA(opA), .opB(opB),
  .accIn(accIn), .outValid(outValid), .result(result)
);

// File: tb/sim_dot_accum_unit.sv
module sim_dot_accum_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, modePair = 1'b0, aSigned = 1'b0, bSigned = 1'b0, hiSel = 1'b0;
  logic [31:0] opA = '0, opB = '0, accIn = '0;
  logic        outValid;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] lastRes = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dot_accum_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modePair(modePair),
    .aSigned(aSigned), .bSigned(bSigned), .hiSel(hiSel),
    .opA(opA), .opB(opB), .accIn(accIn), .outValid(outValid), .result(result)
  );

  function automatic longint ext8(logic [7:0] v, logic s);
    return s ? longint'($signed(v)) : longint'(v);
  endfunction

  function automatic longint ext16(logic [15:0] v, logic s);
    return s ? longint'($signed(v)) : longint'(v);
  endfunction

  // model built from R3, R4, R5, R6 (R8: hiSel unused in quad mode)
  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, logic [31:0] acc,
                                        logic pair, logic as, logic bs, logic hs);
    longint s = longint'(acc);
    if (!pair) begin
      for (int k = 0; k < 4; k++) s += ext8(a[8*k +: 8], as) * ext8(b[8*k +: 8], bs);
    end else begin
      for (int k = 0; k < 2; k++)
        s += ext16(a[16*k +: 16], as) * ext8(b[8*(k + (hs ? 2 : 0)) +: 8], bs);
    end
    return s[31:0];
  endfunction

  function automatic logic [31:0] nextRand(logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample the registered output at the following negedge
  task automatic run(logic [31:0] a, logic [31:0] b, logic [31:0] acc,
                     logic pair, logic as, logic bs, logic hs, string tag);
    opA = a; opB = b; accIn = acc; modePair = pair;
    aSigned = as; bSigned = bs; hiSel = hs; inValid = 1'b1;
    @(negedge clk);
    check("R2 outValid", {31'd0, outValid}, 32'd1);
    check(tag, result, model(a, b, acc, pair, as, bs, hs));
    lastRes = result;
  endtask

  task automatic idle(string tag);
    seed = nextRand(seed);
    opA = seed; opB = ~seed; accIn = seed ^ 32'h5a5a_5a5a;
    modePair = seed[0]; hiSel = seed[1]; inValid = 1'b0;
    @(negedge clk);
    check({tag, " outValid low"}, {31'd0, outValid}, 32'd0);
    check({tag, " result held"}, result, lastRes);
  endtask

  initial begin
    logic [7:0] corner [8] = '{8'h00, 8'h01, 8'h7f, 8'h80, 8'h81, 8'hfe, 8'hff, 8'h55};
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 outValid in reset", {31'd0, outValid}, 32'd0);
    check("R1 result in reset", result, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outValid after reset", {31'd0, outValid}, 32'd0);
    check("R1 result after reset", result, 32'd0);

    // R3/R4/R5 sweep of boundary bytes over lanes, signedness, mode, half
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int sg = 0; sg < 4; sg++)
          for (int md = 0; md < 4; md++) begin
            logic [31:0] a, b;
            a = {corner[j], corner[i], corner[(i+3)%8], corner[(j+5)%8]};
            b = {corner[i], corner[(i+1)%8], corner[j], corner[(j+2)%8]};
            seed = nextRand(seed);
            run(a, b, (i == j) ? 32'd0 : seed, md[1], sg[0], sg[1], md[0],
                md[1] ? "R4 R5 pair sweep" : "R3 R5 quad sweep");
          end

    // R4 extremes of the wide lanes
    run(32'h8000_8000, 32'h0000_8080, 32'd0, 1, 1, 1, 0, "R4 R5 min16 x min8");
    run(32'h8000_8000, 32'h8080_0000, 32'd0, 1, 1, 1, 1, "R4 high bytes");
    run(32'hffff_ffff, 32'hff00_00ff, 32'd7, 1, 0, 0, 0, "R4 R5 unsigned wide");
    run(32'h0001_0002, 32'h0403_0201, 32'd0, 1, 0, 0, 1, "R4 lane order high");
    run(32'h0001_0002, 32'h0403_0201, 32'd0, 1, 0, 0, 0, "R4 lane order low");
    run(32'h0403_0201, 32'h0101_0101, 32'd0, 0, 0, 0, 0, "R3 lane sum");

    // R5 per-operand independence
    run(32'h0000_00ff, 32'h0000_0002, 32'd0, 0, 1, 0, 0, "R5 A signed only");
    run(32'h0000_0002, 32'h0000_00ff, 32'd0, 0, 1, 0, 0, "R5 B unsigned");
    run(32'h0000_0002, 32'h0000_00ff, 32'd0, 0, 0, 1, 0, "R5 B signed only");

    // R6 wrap of the final addition
    run(32'h0000_0001, 32'h0000_0001, 32'hffff_ffff, 0, 0, 0, 0, "R6 wrap to zero");
    run(32'hffff_ffff, 32'hffff_ffff, 32'hffff_fc00, 0, 0, 0, 0, "R6 wrap up");
    run(32'h0000_0001, 32'h0000_00ff, 32'h0000_0000, 0, 0, 1, 0, "R6 wrap down");
    run(32'h7f7f_7f7f, 32'h7f7f_7f7f, 32'h7fff_ffff, 0, 1, 1, 0, "R6 positive overflow");

    // R8 half select ignored in quad mode
    run(32'h1234_5678, 32'h9abc_def0, 32'd3, 0, 1, 0, 1, "R8 hiSel=1 quad");
    run(32'h1234_5678, 32'h9abc_def0, 32'd3, 0, 1, 0, 0, "R8 hiSel=0 quad");

    // R7 hold with junk inputs while idle
    for (int k = 0; k < 6; k++) idle("R7");

    // R2 back-to-back, then random stream with idle gaps
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] a, b, c;
      seed = nextRand(seed); a = seed;
      seed = nextRand(seed); b = seed;
      seed = nextRand(seed); c = seed;
      run(a, b, c, c[0], c[1], c[2], c[3], c[0] ? "R4 random" : "R3 random");
      if (c[7:4] == 4'h0) idle("R7 gap");
    end

    inValid = 1'b0;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule